// File: doc/BRIEF.md
# Cascadable Up/Down Counter Slice

This block is a synchronous counter slice, six bits wide by default, with four operations. A two-bit mode input selects one of them on each rising clock edge: load a parallel value, count up, count down, or keep the present value. A synchronous clear forces the count to zero and overrides every mode.

Counting is gated by two active-low enables, a ripple carry input and a look-ahead carry input. The count advances only while both are low. Each slice reports two active-low outputs. The first is a ripple carry out: it goes low when the slice is counting, both enables are low, and the count sits at the terminal value for the chosen direction. The second is a look-ahead output: it goes low whenever the slice is counting and sits at terminal, whatever the enables are.

In a wide counter, each upper slice takes the ripple carry of the slice below it. As an alternative, an external AND of the lower slices' look-ahead outputs can feed the upper slice's look-ahead input, so the carry enables form in parallel. A slice that is used alone ties both enable inputs low.

Top module: `updn_slice_counter`

## Requirements
- R1: When `masterClear` is high at a rising clock edge, `countOut` becomes 0 on that edge, whatever the mode, data or carry inputs are.
- R2: With `modeSel` = 2'b00 (load), `countOut` takes the value of `presetIn` on the next edge, even when `carryInN` or `lookInN` is high.
- R3: With `modeSel` = 2'b01 (up) and both `carryInN` and `lookInN` low, `countOut` grows by one on each edge, and 63 is followed by 0.
- R4: With `modeSel` = 2'b10 (down) and both `carryInN` and `lookInN` low, `countOut` drops by one on each edge, and 0 is followed by 63.
- R5: With `modeSel` = 2'b11 (keep), `countOut` does not change.
- R6: In the up or down mode, a high `carryInN` leaves `countOut` unchanged on that edge.
- R7: In the up or down mode, a high `lookInN` leaves `countOut` unchanged on that edge.
- R8: `carryOutN` is low exactly when the mode is up or down, `carryInN` and `lookInN` are both low, and the count is at terminal (63 for up, 0 for down). It is high in every other case and follows its inputs within the same cycle.
- R9: `lookOutN` is low exactly when the mode is up or down and the count is at terminal for that direction. It does not depend on `carryInN` or `lookInN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| masterClear | input | 1 | Synchronous clear, active high |
| modeSel | input | 2 | Operation select: 00 load, 01 up, 10 down, 11 keep |
| presetIn | input | 6 | Parallel load value |
| carryInN | input | 1 | Ripple carry enable, active low |
| lookInN | input | 1 | Look-ahead carry enable, active low |
| countOut | output | 6 | Present count |
| carryOutN | output | 1 | Ripple carry out, active low |
| lookOutN | output | 1 | Look-ahead carry out, active low |

## Verification
Two of the block's functions can land in the same cycle, and the bench provokes both pairings. First, a clear can arrive while the mode asks for a load or a count; the bench drives `masterClear` together with the load and up modes and expects a zero count, not the loaded or stepped value. Second, the terminal carry and the wrap both happen at one edge: the count sits at 63 in up mode, or at 0 in down mode. In that cycle the bench checks that `carryOutN` and `lookOutN` are low before the edge, and then that the count wraps to 0 or to 63 after it. The bench also holds the terminal value with one enable high, to show that the look-ahead output stays low while the ripple carry goes high.

// File: rtl/updn_pkg.sv
package updn_pkg;

  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_KEEP = 2'b11
  } modeT;

  typedef struct packed {
    logic clear;
    logic load;
    logic stepUp;
    logic stepDown;
  } strobeT;

endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic       clk,
  input  logic       masterClear,
  input  logic [1:0] modeSel,
  input  logic       carryInN,
  input  logic       lookInN,
  input  logic       atMax,
  input  logic       atMin,
  output strobeT     strobes,
  output logic       carryOutN,
  output logic       lookOutN
);

  modeT mode;
  logic enable;
  logic terminal;
  logic counting;

  always_comb begin
    mode     = modeT'(modeSel);
    enable   = ~carryInN & ~lookInN;
    counting = (mode == MODE_UP) || (mode == MODE_DOWN);
    terminal = ((mode == MODE_UP) && atMax) || ((mode == MODE_DOWN) && atMin);
  end

  always_comb begin
    strobes = '0;
    if (masterClear) begin
      strobes.clear = 1'b1;
    end else begin
      unique case (mode)
        MODE_LOAD: strobes.load     = 1'b1;
        MODE_UP:   strobes.stepUp   = enable;
        MODE_DOWN: strobes.stepDown = enable;
        default:   strobes          = '0;
      endcase
    end
  end

  assign lookOutN  = ~terminal;
  assign carryOutN = ~(terminal & enable);

  // R8
  carry_gate_chk: assert property (@(posedge clk) disable iff (masterClear)
    !carryOutN |-> (!carryInN && !lookInN && counting));

  // R9
  look_mode_chk: assert property (@(posedge clk) disable iff (masterClear)
    !counting |-> lookOutN);

  // R8
  carry_look_chk: assert property (@(posedge clk) disable iff (masterClear)
    !carryOutN |-> !lookOutN);

  // R1
  strobe_onehot_chk: assert property (@(posedge clk)
    $onehot0(strobes));

endmodule

// File: rtl/updn_datapath.sv
module updn_datapath
  import updn_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  strobeT           strobes,
  input  logic [WIDTH-1:0] presetIn,
  output logic [WIDTH-1:0] countQ,
  output logic             atMax,
  output logic             atMin
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] STEP     = WIDTH'(1);

  logic [WIDTH-1:0] countNext;

  always_comb begin
    countNext = countQ;
    if (strobes.clear)         countNext = '0;
    else if (strobes.load)     countNext = presetIn;
    else if (strobes.stepUp)   countNext = countQ + STEP;
    else if (strobes.stepDown) countNext = countQ - STEP;
  end

  always_ff @(posedge clk) begin
    countQ <= countNext;
  end

  assign atMax = (countQ == ALL_ONES);
  assign atMin = (countQ == '0);

  // R1
  clear_zero_chk: assert property (@(posedge clk)
    strobes.clear |=> countQ == '0);

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.load |=> countQ == $past(presetIn));

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.stepUp |=> countQ == $past(countQ) + STEP);

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.stepDown |=> countQ == $past(countQ) - STEP);

  // R5
  idle_keep_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes == '0) |=> $stable(countQ));

endmodule

// File: rtl/updn_slice_counter.sv
module updn_slice_counter
  import updn_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             masterClear,
  input  logic [1:0]       modeSel,
  input  logic [WIDTH-1:0] presetIn,
  input  logic             carryInN,
  input  logic             lookInN,
  output logic [WIDTH-1:0] countOut,
  output logic             carryOutN,
  output logic             lookOutN
);

  strobeT strobes;
  logic   atMax;
  logic   atMin;

  updn_ctrl u_ctrl (
    .clk         (clk),
    .masterClear (masterClear),
    .modeSel     (modeSel),
    .carryInN    (carryInN),
    .lookInN     (lookInN),
    .atMax       (atMax),
    .atMin       (atMin),
    .strobes     (strobes),
    .carryOutN   (carryOutN),
    .lookOutN    (lookOutN)
  );

  updn_datapath #(.WIDTH(WIDTH)) u_data (
    .clk      (clk),
    .strobes  (strobes),
    .presetIn (presetIn),
    .countQ   (countOut),
    .atMax    (atMax),
    .atMin    (atMin)
  );

endmodule

// File: tb/tb_updn_slice_counter.sv
`timescale 1ns/1ps
module tb_updn_slice_counter;

  logic       clk = 1'b0;
  logic       masterClear = 1'b1;
  logic [1:0] modeSel = 2'b11;
  logic [5:0] presetIn = '0;
  logic       carryInN = 1'b0;
  logic       lookInN = 1'b0;
  logic [5:0] countOut;
  logic       carryOutN;
  logic       lookOutN;

  int checks = 0;
  int fails = 0;
  logic [5:0] model = '0;
  bit modelKnown = 0;
  logic [5:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  updn_slice_counter dut (
    .clk(clk), .masterClear(masterClear), .modeSel(modeSel), .presetIn(presetIn),
    .carryInN(carryInN), .lookInN(lookInN), .countOut(countOut),
    .carryOutN(carryOutN), .lookOutN(lookOutN)
  );

  task automatic judge(input logic [5:0] act, input logic [5:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, checks the carries, queues the count due after the edge.
  task automatic step(input logic [1:0] m, input logic [5:0] d, input logic ci,
                      input logic li, input logic clr, input string tag);
    logic term;
    @(negedge clk);
    modeSel = m; presetIn = d; carryInN = ci; lookInN = li; masterClear = clr;
    #0.5;
    if (modelKnown) begin
      term = (m == 2'b01 && model == 6'd63) || (m == 2'b10 && model == 6'd0);
      judge({5'b0, carryOutN}, {5'b0, ~(term & ~ci & ~li)}, {"R8 carryOutN ", tag});
      judge({5'b0, lookOutN}, {5'b0, ~term}, {"R9 lookOutN ", tag});
    end
    if (clr) model = '0;
    else case (m)
      2'b00: model = d;
      2'b01: if (!ci && !li) model = model + 6'd1;
      2'b10: if (!ci && !li) model = model - 6'd1;
      default: model = model;
    endcase
    modelKnown = 1;
    expQ.push_back(model);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares the count one nanosecond after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) judge(countOut, expQ.pop_front(), {"count ", tagQ.pop_front()});
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    step(2'b01, 6'd5, 1'b0, 1'b0, 1'b1, "R1 clear while up");
    step(2'b00, 6'd42, 1'b0, 1'b0, 1'b1, "R1 clear beats load");
    step(2'b00, 6'd60, 1'b1, 1'b1, 1'b0, "R2 load with enables high");
    step(2'b01, 6'd0, 1'b0, 1'b0, 1'b0, "R3 up 61");
    step(2'b01, 6'd0, 1'b0, 1'b0, 1'b0, "R3 up 62");
    step(2'b01, 6'd0, 1'b0, 1'b0, 1'b0, "R3 up 63");
    step(2'b01, 6'd0, 1'b1, 1'b0, 1'b0, "R6 carry-in high at 63");
    step(2'b01, 6'd0, 1'b0, 1'b1, 1'b0, "R7 look-in high at 63");
    step(2'b11, 6'd9, 1'b0, 1'b0, 1'b0, "R5 keep at 63");
    step(2'b01, 6'd0, 1'b0, 1'b0, 1'b0, "R3 wrap to 0");
    step(2'b10, 6'd0, 1'b0, 1'b0, 1'b0, "R4 wrap to 63");
    step(2'b10, 6'd0, 1'b0, 1'b0, 1'b0, "R4 down 62");
    step(2'b10, 6'd0, 1'b1, 1'b0, 1'b0, "R6 carry-in high down");
    step(2'b10, 6'd0, 1'b0, 1'b1, 1'b0, "R7 look-in high down");
    step(2'b00, 6'd1, 1'b0, 1'b0, 1'b0, "R2 load 1");
    step(2'b10, 6'd0, 1'b0, 1'b0, 1'b0, "R4 down to 0");
    step(2'b10, 6'd0, 1'b1, 1'b1, 1'b0, "R8 terminal down gated");
    step(2'b11, 6'd0, 1'b0, 1'b0, 1'b0, "R5 keep at 0");
    step(2'b00, 6'd21, 1'b0, 1'b1, 1'b0, "R2 load 21");
    step(2'b11, 6'd50, 1'b1, 1'b0, 1'b0, "R5 keep at 21");
    for (int i = 0; i < 70; i++) step(2'b01, 6'd0, 1'b0, 1'b0, 1'b0, "R3 long run");
    step(2'b01, 6'd0, 1'b0, 1'b0, 1'b1, "R1 clear during count");
    step(2'b11, 6'd0, 1'b0, 1'b0, 1'b0, "R5 keep after clear");
    @(negedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule